// File: doc/BRIEF.md
# Page-Boundary DMA Request Splitter

This block sits between a DMA command source and a bus transaction builder. It takes one read or write request at a time, given as a byte start address, a byte count and a direction. It turns that request into a series of transaction descriptors. No descriptor covers a byte range that straddles a 4 KB address boundary. Requests may start at any byte address and may have any non-zero length. The splitting is done entirely in hardware, so host software never has to pre-cut its buffers.

Each piece is also capped by a selectable maximum payload size. The piece length is the smallest of three values: the bytes still owed, the bytes left before the next 4 KB boundary, and that cap. Pieces leave through a valid/ready channel in address order. The final piece carries a last flag. A zero-length request is consumed, produces an error pulse, and emits nothing.

Top module: `page_split_dma`

## Requirements
- R1: After reset, dsc_valid_o and err_o are low and req_ready_o is high.
- R2: No emitted descriptor covers bytes on both sides of a 4 KB boundary, so (dsc_addr_o mod 0x1000) + dsc_len_o never exceeds 0x1000.
- R3: When a request crosses a boundary, the piece before the crossing ends on the byte just below the boundary, and the following piece starts exactly on it. For example, 0x1234FF00 with 0x200 bytes and a cap of 1024 becomes 0x1234FF00/0x100 followed by 0x12350000/0x100.
- R4: A request that lies within one 4 KB page and is no longer than the cap leaves as one descriptor with the same address and length, with dsc_last_o high.
- R5: Requests are accepted at any byte alignment, and the pieces still follow R2, R7 and R8.
- R6: dsc_wr_o on every piece equals the req_wr_i of its request, where 1 means write and 0 means read. Both directions are split the same way.
- R7: The payload cap is 128 << mps_sel_i bytes, with codes 0..3 meaning 128, 256, 512 and 1024 bytes. Each piece length is the minimum of the remaining bytes, the bytes left to the boundary, and the cap.
- R8: Piece addresses are contiguous, starting at the request address. Piece lengths sum to the request length. dsc_last_o is high only on the final piece.
- R9: A request with req_len_i equal to 0 is accepted. err_o is high for exactly the one cycle after acceptance, and no descriptor is emitted.
- R10: While any piece of a request is still pending, req_ready_o stays low, so descriptors come out in request order. The first piece is valid in the cycle after acceptance.
- R11: While dsc_valid_o is high and dsc_ready_i is low, the descriptor fields and dsc_valid_o hold.
- R12: mps_sel_i is sampled when a request is accepted. Changing it while that request is being split has no effect on its pieces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mps_sel_i | input | 2 | Payload cap code, where the cap is 128 << code bytes |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_addr_i | input | ADDR_W | Request start byte address |
| req_len_i | input | LEN_W | Request byte count |
| req_wr_i | input | 1 | Direction, where 1 means write and 0 means read |
| dsc_valid_o | output | 1 | Descriptor valid |
| dsc_ready_i | input | 1 | Descriptor ready |
| dsc_addr_o | output | ADDR_W | Piece start address |
| dsc_len_o | output | LEN_W | Piece byte count |
| dsc_wr_o | output | 1 | Piece direction |
| dsc_last_o | output | 1 | Final piece of the request |
| err_o | output | 1 | Zero-length request pulse |

## Verification
Directed requests cover several cases: the two-piece boundary example, a request exactly filling a page, a one-byte request on the last byte of a page, and a zero-length request. Together these separate an off-by-one in the boundary room from a wrong last flag. Random requests bias their start addresses towards the end of a page and draw lengths up to several pages under all four cap codes. This separates cuts forced by the boundary from cuts forced by the cap. Random back-pressure on the descriptor side shows whether fields move during a stall. Changing the cap code in the middle of a request shows whether the code is wrongly re-read while a request is being split.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    MPS_128  = 2'd0,
    MPS_256  = 2'd1,
    MPS_512  = 2'd2,
    MPS_1024 = 2'd3
  } mps_sel_e;
endpackage

// File: rtl/pbs_piece_calc.sv
module pbs_piece_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_W     = 12,
  parameter int MPS_BASE_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  rem_i,
  input  pbs_pkg::mps_sel_e sel_i,
  output logic [LEN_W-1:0]  piece_len_o,
  output logic              piece_last_o
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_W;

  logic [LEN_W-1:0] room;
  logic [LEN_W-1:0] cap;
  logic [LEN_W-1:0] limit;

  always_comb begin
    room  = PAGE_BYTES - LEN_W'(addr_i[PAGE_W-1:0]);
    cap   = LEN_W'(1) << (MPS_BASE_W + int'(sel_i));
    limit = (room < cap) ? room : cap;
    if (rem_i <= limit) begin
      piece_len_o  = rem_i;
      piece_last_o = 1'b1;
    end else begin
      piece_len_o  = limit;
      piece_last_o = 1'b0;
    end
  end
endmodule

// File: rtl/pbs_walker.sv
module pbs_walker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [LEN_W-1:0]  load_len_i,
  input  logic              load_wr_i,
  input  pbs_pkg::mps_sel_e load_sel_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  piece_len_i,
  input  logic              piece_last_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic              wr_o,
  output pbs_pkg::mps_sel_e sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      addr_o <= '0;
      rem_o  <= '0;
      wr_o   <= 1'b0;
      sel_o  <= pbs_pkg::MPS_128;
    end else if (load_i) begin
      busy_o <= 1'b1;
      addr_o <= load_addr_i;
      rem_o  <= load_len_i;
      wr_o   <= load_wr_i;
      sel_o  <= load_sel_i;
    end else if (step_i) begin
      addr_o <= addr_o + ADDR_W'(piece_len_i);
      rem_o  <= rem_o - piece_len_i;
      busy_o <= !piece_last_i;
    end
  end

  // R8: next piece starts where the previous one ended
  a_r8_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !piece_last_i && !load_i) |=>
      (busy_o && addr_o == $past(addr_o) + ADDR_W'($past(piece_len_i))))
    else $error("a_r8_contiguous");

  // R12: cap code frozen while splitting
  a_r12_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> $stable(sel_o))
    else $error("a_r12_sel_frozen");
endmodule

// File: rtl/page_split_dma.sv
module page_split_dma #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_W     = 12,
  parameter int MPS_BASE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mps_sel_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_wr_i,
  output logic              dsc_valid_o,
  input  logic              dsc_ready_i,
  output logic [ADDR_W-1:0] dsc_addr_o,
  output logic [LEN_W-1:0]  dsc_len_o,
  output logic              dsc_wr_o,
  output logic              dsc_last_o,
  output logic              err_o
);
  localparam logic [LEN_W:0] PAGE_BYTES_X = (LEN_W+1)'(1) << PAGE_W;

  logic              busy;
  logic              req_fire;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_rem;
  logic              cur_wr;
  pbs_pkg::mps_sel_e cur_sel;
  logic [LEN_W-1:0]  piece_len;
  logic              piece_last;
  logic              err_q;

  assign req_ready_o = !busy;
  assign req_fire    = req_valid_i && req_ready_o;
  assign load        = req_fire && (req_len_i != '0);
  assign step        = busy && dsc_ready_i;

  pbs_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_addr_i  (req_addr_i),
    .load_len_i   (req_len_i),
    .load_wr_i    (req_wr_i),
    .load_sel_i   (pbs_pkg::mps_sel_e'(mps_sel_i)),
    .step_i       (step),
    .piece_len_i  (piece_len),
    .piece_last_i (piece_last),
    .busy_o       (busy),
    .addr_o       (cur_addr),
    .rem_o        (cur_rem),
    .wr_o         (cur_wr),
    .sel_o        (cur_sel)
  );

  pbs_piece_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .MPS_BASE_W(MPS_BASE_W)
  ) u_calc (
    .addr_i       (cur_addr),
    .rem_i        (cur_rem),
    .sel_i        (cur_sel),
    .piece_len_o  (piece_len),
    .piece_last_o (piece_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= req_fire && (req_len_i == '0);
  end

  assign dsc_valid_o = busy;
  assign dsc_addr_o  = cur_addr;
  assign dsc_len_o   = piece_len;
  assign dsc_wr_o    = cur_wr;
  assign dsc_last_o  = piece_last;
  assign err_o       = err_q;

  a_r2_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_valid_o |->
      ((LEN_W+1)'(dsc_addr_o[PAGE_W-1:0]) + (LEN_W+1)'(dsc_len_o) <= PAGE_BYTES_X))
    else $error("a_r2_no_cross");

  a_r7_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_valid_o |-> (dsc_len_o != '0 &&
      dsc_len_o <= (LEN_W'(1) << (MPS_BASE_W + int'(cur_sel)))))
    else $error("a_r7_len_bound");

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsc_valid_o && !dsc_ready_i) |=>
      (dsc_valid_o && $stable(dsc_addr_o) && $stable(dsc_len_o) &&
       $stable(dsc_wr_o) && $stable(dsc_last_o)))
    else $error("a_r11_hold");

  a_r10_first_piece: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i != '0) |=>
      (dsc_valid_o && !req_ready_o))
    else $error("a_r10_first_piece");

  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!dsc_valid_o && !$past(err_o)))
    else $error("a_r9_err_quiet");
endmodule

// File: tb/tb_page_split_dma.sv
module tb_page_split_dma;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        mps_sel_i = 2'd0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              req_wr_i = 1'b0;
  logic              dsc_valid_o;
  logic              dsc_ready_i = 1'b0;
  logic [ADDR_W-1:0] dsc_addr_o;
  logic [LEN_W-1:0]  dsc_len_o;
  logic              dsc_wr_o;
  logic              dsc_last_o;
  logic              err_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  page_split_dma dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_piece(input logic [31:0] a, input int rem, input int sel);
    int room, cap, lim;
    room = 4096 - int'(a[11:0]);
    cap  = 128 << sel;
    lim  = (room < cap) ? room : cap;
    return (rem < lim) ? rem : lim;
  endfunction

  // Sends one request and follows its pieces; starts and ends at a negedge.
  task automatic run_req(input logic [31:0] a, input int len, input bit wr,
                         input int sel, input bit bp, input bit twist_sel);
    logic [31:0] ea;
    int erem, ep, npc, guard;
    logic [31:0] pa; int pl; bit pw, plast, pstall;
    check(req_ready_o == 1'b1, "R10 ready before request", req_ready_o, 1);
    mps_sel_i   = sel[1:0];
    req_addr_i  = a;
    req_len_i   = len[LEN_W-1:0];
    req_wr_i    = wr;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (twist_sel) mps_sel_i = 2'(sel + 1 + int'($urandom_range(0, 2)));
    if (len == 0) begin
      check(err_o == 1'b1, "R9 err pulse", err_o, 1);
      check(dsc_valid_o == 1'b0, "R9 no descriptor", dsc_valid_o, 0);
      @(negedge clk_i);
      check(err_o == 1'b0, "R9 err one cycle", err_o, 0);
      check(dsc_valid_o == 1'b0, "R9 still no descriptor", dsc_valid_o, 0);
      return;
    end
    check(err_o == 1'b0, "R9 no err on nonzero", err_o, 0);
    ea = a; erem = len; npc = 0; pstall = 0; guard = 0;
    pa = '0; pl = 0; pw = 0; plast = 0;
    while (erem > 0 && guard < 4000) begin
      guard++;
      dsc_ready_i = bp ? ($urandom_range(0, 2) != 0) : 1'b1;
      check(dsc_valid_o == 1'b1, "R10 piece valid", dsc_valid_o, 1);
      check(req_ready_o == 1'b0, "R10 ready low while pending", req_ready_o, 0);
      if (pstall)
        check(dsc_addr_o == pa && int'(dsc_len_o) == pl && dsc_wr_o == pw && dsc_last_o == plast,
              "R11 hold under stall", dsc_addr_o, pa);
      ep = exp_piece(ea, erem, sel);
      check(dsc_addr_o == ea, "R8 piece address", dsc_addr_o, ea);
      check(int'(dsc_len_o) == ep, "R7 piece length", dsc_len_o, ep);
      check(dsc_wr_o == wr, "R6 direction", dsc_wr_o, wr);
      check(dsc_last_o == (ep == erem), "R8 last flag", dsc_last_o, (ep == erem));
      check(int'(dsc_addr_o[11:0]) + int'(dsc_len_o) <= 4096, "R2 no boundary cross",
            int'(dsc_addr_o[11:0]) + int'(dsc_len_o), 4096);
      pa = dsc_addr_o; pl = int'(dsc_len_o); pw = dsc_wr_o; plast = dsc_last_o;
      pstall = !dsc_ready_i;
      if (dsc_ready_i) begin
        ea = ea + 32'(ep); erem = erem - ep; npc++;
      end
      @(negedge clk_i);
    end
    dsc_ready_i = 1'b0;
    check(dsc_valid_o == 1'b0, "R8 no piece after last", dsc_valid_o, 0);
    check(req_ready_o == 1'b1, "R10 ready after last", req_ready_o, 1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    // R1
    check(dsc_valid_o == 1'b0, "R1 reset valid", dsc_valid_o, 0);
    check(err_o == 1'b0, "R1 reset err", err_o, 0);
    check(req_ready_o == 1'b1, "R1 reset ready", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(dsc_valid_o == 1'b0, "R1 idle after reset", dsc_valid_o, 0);

    // R3 documented crossing
    run_req(32'h1234FF00, 'h200, 1'b0, 3, 1'b0, 1'b0);
    // R4 single piece pass-through, both directions (R6)
    run_req(32'h00002040, 'h80, 1'b1, 0, 1'b0, 1'b0);
    run_req(32'h00002040, 'h80, 1'b0, 0, 1'b1, 1'b0);
    // R5 one byte on last byte of page, odd start, exact page end
    run_req(32'h00000FFF, 1, 1'b1, 2, 1'b0, 1'b0);
    run_req(32'h00000C01, 'h3FF, 1'b0, 3, 1'b1, 1'b0);
    run_req(32'h00003000, 'h1000, 1'b1, 3, 1'b1, 1'b0);
    // R9 zero length
    run_req(32'h00004000, 0, 1'b0, 1, 1'b0, 1'b0);
    // R12 cap code changed mid-request
    run_req(32'h00005F10, 'h600, 1'b1, 0, 1'b1, 1'b1);
    // R11 and random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a; int len;
      a = $urandom;
      if ($urandom_range(0, 1) == 1) a[11:0] = 12'(4096 - int'($urandom_range(1, 300)));
      case ($urandom_range(0, 3))
        0: len = int'($urandom_range(1, 64));
        1: len = int'($urandom_range(1, 1100));
        2: len = int'($urandom_range(1, 6000));
        default: len = ($urandom_range(0, 19) == 0) ? 0 : int'($urandom_range(1, 4096));
      endcase
      run_req(a, len, 1'($urandom), int'($urandom_range(0, 3)),
              1'($urandom), ($urandom_range(0, 3) == 0));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule